// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Compressor

This block is a synthesizable behavioural model of the test-mode logic on the memory side of a multiplexed-address DRAM with four data pins. The strobes are active low: row strobe, column strobe, write enable and output enable. The model reads the order in which they move and from that decides whether the device is in normal or test mode. Electrical timing is reduced to the order of events on a sampling clock. Every strobe and address value is taken at a rising edge of `clk`.

The storage is built as two half-depth sectors per data pin. In normal mode the top column-address bit picks one of the two sectors, so the device behaves as a full-depth, four-bit-wide memory. In test mode that column bit is ignored. Each write lands in both sectors at once. Each read folds the two sector bits behind a pin into one agreement bit. A whole device can then be checked in half the number of accesses.

Entry into test mode and exit from it ride on refresh cycles. A column-before-row refresh with write enable low enters test mode. The same refresh with write enable high leaves it. A row-only refresh also leaves it. Every column-before-row refresh steps an internal refresh row counter, whatever the mode. Compressed reads cost one extra sampling cycle of access time.

Top module: `tmc_dram`

## Requirements
- R1: After reset, `test_mode` is 0 and `dq_oe` is 0. `dq_out` is 0 whenever `dq_oe` is 0.
- R2: In normal mode, a column access is a column-strobe fall sampled while a row is open. If `we_n` is high at that edge, it is a read. The read data is the word stored at {row, column}. The top column bit (bit ADDR_W-1) selects sector 0 (value 0) or sector 1 (value 1). `dq_oe` rises in the first sampling cycle after that edge.
- R3: A row-strobe fall while the column strobe is already low is a refresh. If `we_n` is low at that edge, `test_mode` is 1 from the next cycle on.
- R4: The same refresh with `we_n` high sets `test_mode` to 0.
- R5: A row cycle that opens and closes with no column-strobe fall sets `test_mode` to 0 at the edge where the row strobe rises. `test_mode` keeps its value while that row is still open.
- R6: A refresh with `we_n` low issued while already in test mode keeps test mode and leaves stored data unchanged. Every refresh advances the internal refresh row counter by one.
- R7: In test mode, a write stores the pin values into both sectors at index {row, column bits ADDR_W-2..0}. The top column bit has no effect on where the data goes.
- R8: In test mode, a read returns for each pin p the value 1 when sector 0 bit p equals sector 1 bit p, and 0 when they differ.
- R9: A test-mode read drives `dq_oe` one sampling cycle later than a normal read, that is, in the second cycle after the column-strobe fall.
- R10: `dq_oe` is 1 only during a read, only while the column strobe and `oe_n` are low. A write (`we_n` low at the column-strobe fall) never drives the pins. Raising the column strobe ends the drive.
- R11: Several column accesses inside one open row (page mode) each use that row and their own column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, returns to normal mode |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the pins |
| dq_out | output | DQ_W | Read data to the pins |
| dq_oe | output | 1 | Pin drive enable for dq_out |
| test_mode | output | 1 | 1 while in compressed test mode |

## Verification
The bench builds the block with ADDR_W = 4 and DQ_W = 4. That gives sixteen rows of sixteen columns, with columns 0 to 7 in sector 0 and 8 to 15 in sector 1. With this size, sector pairs can hold chosen agreeing and differing patterns in a few writes. Each pair can then be seen both through the compressed read and through the plain per-sector read after leaving test mode. The small row count also lets page-mode, row-only and refresh cycles be mixed within one short run.

// File: rtl/tmc_pkg.sv
`timescale 1ns/1ps
package tmc_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_TEST   = 1'b1
  } mode_e;

  // Mode chosen by a column-before-row refresh: write enable low selects test.
  function automatic mode_e mode_on_refresh(input logic we_low_n);
    return we_low_n ? MODE_NORMAL : MODE_TEST;
  endfunction

  // Compression of one pin: 1 when both sector bits agree.
  function automatic logic pin_agree(input logic lo, input logic hi);
    return ~(lo ^ hi);
  endfunction

endpackage

// File: rtl/tmc_strobe_dec.sv
`timescale 1ns/1ps
module tmc_strobe_dec
  import tmc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_q,
  output logic              rd_ev,
  output logic              wr_ev,
  output logic              cas_rise,
  output logic              cbr_ev,
  output logic              ras_only_ev,
  output logic              test_mode,
  output logic [ADDR_W-1:0] ref_row
);

  localparam logic [ADDR_W-1:0] REF_STEP = ADDR_W'(1);

  logic  ras_d, cas_d;
  logic  row_open, cas_seen;
  logic  ras_fall, ras_rise, cas_fall, acc_open, col_acc;
  mode_e mode_q, mode_d;
  logic [ADDR_W-1:0] row_r, ref_q;

  // Edge detection against the previous sample
  assign ras_fall = ras_d & ~ras_n;
  assign ras_rise = ~ras_d & ras_n;
  assign cas_fall = cas_d & ~cas_n;
  assign cas_rise = ~cas_d & cas_n;

  // Access row opens only when the column strobe was high before
  assign acc_open    = ras_fall & cas_d;
  assign cbr_ev      = ras_fall & ~cas_d & ~cas_n;
  assign col_acc     = cas_fall & row_open;
  assign rd_ev       = col_acc & we_n;
  assign wr_ev       = col_acc & ~we_n;
  assign ras_only_ev = ras_rise & row_open & ~cas_seen;

  always_comb begin
    mode_d = mode_q;
    if (cbr_ev)
      mode_d = mode_on_refresh(we_n);
    else if (ras_only_ev)
      mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_d    <= 1'b1;
      cas_d    <= 1'b1;
      row_open <= 1'b0;
      cas_seen <= 1'b0;
      row_r    <= '0;
      ref_q    <= '0;
      mode_q   <= MODE_NORMAL;
    end else begin
      ras_d  <= ras_n;
      cas_d  <= cas_n;
      mode_q <= mode_d;
      if (acc_open) begin
        row_open <= 1'b1;
        cas_seen <= 1'b0;
        row_r    <= addr;
      end else if (ras_rise) begin
        row_open <= 1'b0;
      end else if (col_acc) begin
        cas_seen <= 1'b1;
      end
      if (cbr_ev)
        ref_q <= ref_q + REF_STEP;
    end
  end

  assign row_q     = row_r;
  assign test_mode = (mode_q == MODE_TEST);
  assign ref_row   = ref_q;

endmodule

// File: rtl/tmc_sector_array.sv
`timescale 1ns/1ps
module tmc_sector_array #(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 4
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic                     wr_both,
  input  logic                     sel,
  input  logic [2*ADDR_W-2:0]      idx,
  input  logic [DQ_W-1:0]          wr_data,
  output logic [1:0][DQ_W-1:0]     rd_word
);

  localparam int IDX_W = 2 * ADDR_W - 1;
  localparam int DEPTH = 2 ** IDX_W;

  for (genvar s = 0; s < 2; s++) begin : g_sec
    logic [DQ_W-1:0] mem [DEPTH];
    logic            hit;

    assign hit = wr_en & (wr_both | (sel == 1'(s)));

    always_ff @(posedge clk) begin
      if (hit)
        mem[idx] <= wr_data;
    end

    assign rd_word[s] = mem[idx];
  end

endmodule

// File: rtl/tmc_read_path.sv
`timescale 1ns/1ps
module tmc_read_path
  import tmc_pkg::*;
#(
  parameter int DQ_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_ev,
  input  logic                 cas_rise,
  input  logic                 test_mode,
  input  logic                 sel,
  input  logic [1:0][DQ_W-1:0] rd_word,
  output logic                 rd_valid,
  output logic [DQ_W-1:0]      rd_data
);

  logic [DQ_W-1:0] agree, plain, stage_q, data_q;
  logic            pend_q, valid_q;

  for (genvar p = 0; p < DQ_W; p++) begin : g_pin
    assign agree[p] = pin_agree(rd_word[0][p], rd_word[1][p]);
  end

  assign plain = sel ? rd_word[1] : rd_word[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      data_q  <= '0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (cas_rise) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (rd_ev) begin
      if (test_mode) begin
        stage_q <= agree;
        pend_q  <= 1'b1;
        valid_q <= 1'b0;
      end else begin
        data_q  <= plain;
        valid_q <= 1'b1;
      end
    end else if (pend_q) begin
      data_q  <= stage_q;
      pend_q  <= 1'b0;
      valid_q <= 1'b1;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

endmodule

// File: rtl/tmc_dram.sv
`timescale 1ns/1ps
module tmc_dram #(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              test_mode
);

  localparam int IDX_W = 2 * ADDR_W - 1;

  function automatic logic [IDX_W-1:0] cell_index(input logic [ADDR_W-1:0] row,
                                                  input logic [ADDR_W-1:0] col);
    return {row, col[ADDR_W-2:0]};
  endfunction

  logic [ADDR_W-1:0]     row_q, ref_row;
  logic                  rd_ev, wr_ev, cas_rise, cbr_ev, ras_only_ev;
  logic                  rd_valid;
  logic [DQ_W-1:0]       rd_data;
  logic [1:0][DQ_W-1:0]  rd_word;
  logic [IDX_W-1:0]      idx;
  logic                  sec_sel;

  tmc_strobe_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .row_q      (row_q),
    .rd_ev      (rd_ev),
    .wr_ev      (wr_ev),
    .cas_rise   (cas_rise),
    .cbr_ev     (cbr_ev),
    .ras_only_ev(ras_only_ev),
    .test_mode  (test_mode),
    .ref_row    (ref_row)
  );

  assign idx     = cell_index(row_q, addr);
  assign sec_sel = addr[ADDR_W-1];

  tmc_sector_array #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_arr (
    .clk    (clk),
    .wr_en  (wr_ev),
    .wr_both(test_mode),
    .sel    (sec_sel),
    .idx    (idx),
    .wr_data(dq_in),
    .rd_word(rd_word)
  );

  tmc_read_path #(.DQ_W(DQ_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_ev    (rd_ev),
    .cas_rise (cas_rise),
    .test_mode(test_mode),
    .sel      (sec_sel),
    .rd_word  (rd_word),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign dq_oe  = rd_valid & ~cas_n & ~oe_n;
  assign dq_out = dq_oe ? rd_data : '0;

endmodule

// File: rtl/tmc_dram_chk.sv
`timescale 1ns/1ps
module tmc_dram_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              cbr_ev,
  input logic              ras_only_ev,
  input logic              rd_ev,
  input logic              wr_ev,
  input logic              test_mode,
  input logic [ADDR_W-1:0] ref_row,
  input logic              rd_valid,
  input logic              dq_oe
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  AST_ENTER_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_ev && !we_n) |=> test_mode);  // R3

  AST_LEAVE_BY_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_ev && we_n) |=> !test_mode);  // R4

  AST_LEAVE_BY_ROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ras_only_ev |=> !test_mode);  // R5

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbr_ev && !ras_only_ev) |=> (test_mode == $past(test_mode)));  // R5

  AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_ev |=> (ref_row == $past(ref_row) + ONE));  // R6

  AST_NORMAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !test_mode) |=> rd_valid);  // R2

  AST_TEST_EARLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && test_mode) |=> !rd_valid);  // R9

  AST_TEST_LATE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && test_mode) ##1 !cas_n |=> rd_valid);  // R9

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> !dq_oe);  // R10

  AST_CAS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n && $past(cas_n)) |-> !rd_valid);  // R10

endmodule

bind tmc_dram tmc_dram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .cbr_ev     (cbr_ev),
  .ras_only_ev(ras_only_ev),
  .rd_ev      (rd_ev),
  .wr_ev      (wr_ev),
  .test_mode  (test_mode),
  .ref_row    (ref_row),
  .rd_valid   (rd_valid),
  .dq_oe      (dq_oe)
);

// File: tb/sim_tmc_dram.sv
`timescale 1ns/1ps
module sim_tmc_dram;
  localparam int ADDR_W = 4;
  localparam int DQ_W   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DQ_W-1:0]   dq_in = '0;
  logic [DQ_W-1:0]   dq_out;
  logic              dq_oe, test_mode;

  tmc_dram #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .test_mode(test_mode)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [DQ_W-1:0] data;
    int              due;
    string           tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item at every new drive of the pins
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (dq_oe && !oe_prev) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 drive without a read", int'(dq_out), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(dq_out == e.data, e.tag, int'(dq_out), int'(e.data));
          check(cyc == e.due, {e.tag, " latency"}, cyc, e.due);
        end
      end
      oe_prev = dq_oe;
    end
  end

  task automatic row_open(input logic [ADDR_W-1:0] row);
    @(negedge clk); addr = row; ras_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic row_close();
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic col_write(input logic [ADDR_W-1:0] col, input logic [DQ_W-1:0] d,
                           input string tag);
    @(negedge clk); addr = col; we_n = 1'b0; dq_in = d; cas_n = 1'b0;
    @(negedge clk);
    check(dq_oe == 1'b0, {tag, " write keeps pins idle"}, int'(dq_oe), 0);
    cas_n = 1'b1; we_n = 1'b1;
  endtask

  // Driver: pushes the expected word and its due cycle, then holds the column strobe
  task automatic col_read(input logic [ADDR_W-1:0] col, input logic [DQ_W-1:0] exp,
                          input int lat, input string tag);
    @(negedge clk); addr = col; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0;
    sb.push_back('{exp, cyc + lat, tag});
    repeat (3) @(negedge clk);
    cas_n = 1'b1;
  endtask

  task automatic refresh_cbr(input logic we);
    @(negedge clk); cas_n = 1'b0; we_n = we;
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk);
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(test_mode == 1'b0, "R1 mode after reset", int'(test_mode), 0);
    check(dq_oe == 1'b0, "R1 pins idle after reset", int'(dq_oe), 0);
    check(dq_out == '0, "R1 data zero when idle", int'(dq_out), 0);

    // Normal writes into both sectors of row 5, one word in row 3
    row_open(4'd5);
    col_write(4'h2, 4'hA, "R2");
    col_write(4'hA, 4'h6, "R2");
    col_write(4'h3, 4'h9, "R10");
    col_write(4'hB, 4'h9, "R10");
    row_close();
    row_open(4'd3);
    col_write(4'h2, 4'h1, "R2");
    row_close();

    // Normal page-mode reads
    row_open(4'd5);
    col_read(4'h2, 4'hA, 1, "R2 sector0 read");
    col_read(4'hA, 4'h6, 1, "R11 page read sector1");
    row_close();
    row_open(4'd3);
    col_read(4'h2, 4'h1, 1, "R11 other row");
    row_close();

    // Enter test mode
    refresh_cbr(1'b0);
    check(test_mode == 1'b1, "R3 enter test", int'(test_mode), 1);

    row_open(4'd5);
    col_read(4'h2, 4'h3, 2, "R8 compressed differing pins");
    col_read(4'hB, 4'hF, 2, "R8 compressed agreeing pins");
    col_read(4'h3, 4'hF, 2, "R7 top column bit ignored on read");
    col_write(4'hC, 4'h5, "R7");
    col_read(4'h4, 4'hF, 2, "R7 duplicated write agrees");
    row_close();

    // Refresh with write enable low while in test mode
    refresh_cbr(1'b0);
    check(test_mode == 1'b1, "R6 stays in test", int'(test_mode), 1);
    row_open(4'd5);
    col_read(4'h2, 4'h3, 2, "R6 data kept after refresh");
    row_close();

    // Leave by refresh with write enable high
    refresh_cbr(1'b1);
    check(test_mode == 1'b0, "R4 leave by refresh", int'(test_mode), 0);
    row_open(4'd5);
    col_read(4'h4, 4'h5, 1, "R7 sector0 copy");
    col_read(4'hC, 4'h5, 1, "R7 sector1 copy");
    col_read(4'h2, 4'hA, 1, "R11 untouched word");
    row_close();

    // Leave by row-only refresh
    refresh_cbr(1'b0);
    check(test_mode == 1'b1, "R3 re-enter test", int'(test_mode), 1);
    row_open(4'd0);
    check(test_mode == 1'b1, "R5 held while row open", int'(test_mode), 1);
    row_close();
    check(test_mode == 1'b0, "R5 leave by row-only", int'(test_mode), 0);
    row_open(4'd3);
    col_read(4'h2, 4'h1, 1, "R5 normal read after exit");

    // Output enable high blocks the drive
    @(negedge clk); oe_n = 1'b1; we_n = 1'b1; addr = 4'h2; cas_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(dq_oe == 1'b0, "R10 output enable high", int'(dq_oe), 0);
    cas_n = 1'b1;
    @(negedge clk); oe_n = 1'b0;
    row_close();

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 all reads returned", sb.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule